// File: doc/BRIEF.md
# JTAG Burst Write Receiver

This block sits behind a debug TAP and turns a serial burst of write data into bus write cycles. A neighbouring command decoder hands it a decoded burst-write command (word size code, start address, word count) with a one-cycle load strobe. The receiver then watches the Shift-DR bit stream on TDI. It waits for a leading 1 that marks the start of the payload, then gathers words least significant bit first. Each complete word is sent to the bus at an address that steps by the word size in bytes.

After every word, one extra shift clock gives a status slot. During that slot the block drives TDO with 1 if the bus took the word, or 0 if the bus was still busy and the word was dropped. After the last word, 32 CRC bits follow. The block compares them with its own reflected CRC over every data bit it received, and drives the result as a single match bit on TDO. A bus error latches a sticky flag together with the failing address, forming a 33-bit error register that the host reads and clears through the decoder. Update-DR or Test-Logic-Reset drops the block back to idle at any point.

Top module: `bwr_burst_write`

## Requirements
- R1: After a command load, 0 bits shifted in are ignored and TDO stays 0. The first 1 bit is the start bit, and the bit after it is bit 0 of the first word.
- R2: The size code selects the word width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Words arrive LSB first and appear right-aligned on `bus_wdata`, with the upper bits zero.
- R3: The first word goes to the command address. Each later word goes to the previous address plus the word size in bytes (1, 2 or 4). The address advances even when a word is dropped.
- R4: On the shift edge that completes a word, if `bus_busy` is low, `bus_wr` is high for exactly the next cycle with the word's address, data and size code, and TDO reads 1 during the following status slot.
- R5: If `bus_busy` is high on the edge that completes a word, no write is issued and TDO reads 0 during the status slot.
- R6: Each word is followed by exactly one status shift clock. TDI in that clock is ignored.
- R7: After the last word's status slot (or right after the start bit when the word count is 0), 32 CRC bits arrive LSB first. TDO then shows 1 if they equal the locally computed CRC and 0 otherwise, and holds that value until abort or reload. The CRC is bit-serial and reflected, with initial value 0xFFFFFFFF and polynomial 0xEDB88320. It covers every received data bit, including the bits of dropped words.
- R8: A `bus_err` pulse sets the sticky `err_flag` and captures the address of the most recent issued write into `err_addr`. While the flag is set, later errors do not change the address. `err_clr` clears the flag, but an error in the same cycle wins over the clear.
- R9: `update` or `tlr` returns the block to idle with TDO low and no write issued. Any partial word and partial CRC are discarded, and the next command starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| update | input | 1 | TAP is in Update-DR |
| shift | input | 1 | TAP is in Shift-DR |
| tdi | input | 1 | Serial data in |
| cmd_load | input | 1 | One-cycle strobe of a decoded burst-write command |
| cmd_size | input | 2 | Word size code (0: 8, 1: 16, 2/3: 32 bits) |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_len | input | LEN_W | Number of words |
| tdo | output | 1 | Status or CRC match bit |
| bus_wr | output | 1 | One-cycle write request |
| bus_addr | output | ADDR_W | Write address |
| bus_wdata | output | 32 | Right-aligned write data |
| bus_size | output | 2 | Size code of the write |
| bus_busy | input | 1 | Bus still working on an earlier write |
| bus_err | input | 1 | Bus reports a failed write |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky bus error flag |
| err_addr | output | ADDR_W | Address of the first failed write |

## Verification
The bench goes after the places where the bit count or the slot alignment can slip. It drives leading zeros before the start bit, words of every size code, and a 1 on TDI during status slots; a receiver that miscounted would scramble data or shift the CRC by a bit. A word dropped while the bus is busy must still advance the address and still feed the CRC, so a design that skipped either would show a wrong address on the next write or a false CRC mismatch. A zero-length burst, a corrupted CRC, and aborts in the middle of a word and in the middle of the CRC check that the match bit and the fresh start do not inherit stale state. The error register is checked for a sticky flag, a first address that later errors do not overwrite, and a set that wins over a clear in the same cycle.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  localparam int DATA_W = 32;
  localparam int CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_DATA, ST_STAT, ST_CRC, ST_MATCH
  } bwr_state_e;

  // one serial step of the reflected CRC
  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [5:0] size_bits(logic [1:0] code);
    case (code)
      2'd0:    size_bits = 6'd8;
      2'd1:    size_bits = 6'd16;
      default: size_bits = 6'd32;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(logic [1:0] code);
    case (code)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/bwr_crc32.sv
module bwr_crc32
  import bwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             data_en,
  input  logic             data_bit,
  input  logic             rx_en,
  input  logic             rx_bit,
  output logic             match_now
);

  logic [CRC_W-1:0] calc_q;
  logic [CRC_W-1:0] rx_q;
  logic [CRC_W-1:0] rx_next;

  assign rx_next   = {rx_bit, rx_q[CRC_W-1:1]};
  assign match_now = (rx_next == calc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_q <= CRC_SEED;
      rx_q   <= '0;
    end else if (clr) begin
      calc_q <= CRC_SEED;
      rx_q   <= '0;
    end else begin
      if (data_en) calc_q <= crc_step(calc_q, data_bit);
      if (rx_en)   rx_q   <= rx_next;
    end
  end

endmodule

// File: rtl/bwr_errlog.sv
module bwr_errlog #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_err,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic              err_clr,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_addr <= '0;
    end else if (bus_err) begin
      if (!err_flag || err_clr) err_addr <= fail_addr;
      err_flag <= 1'b1;
    end else if (err_clr) begin
      err_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/bwr_burst_write.sv
module bwr_burst_write
  import bwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlr,
  input  logic              update,
  input  logic              shift,
  input  logic              tdi,
  input  logic              cmd_load,
  input  logic [1:0]        cmd_size,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              tdo,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [1:0]        bus_size,
  input  logic              bus_busy,
  input  logic              bus_err,
  input  logic              err_clr,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);

  localparam int CNT_W = $clog2(DATA_W);

  bwr_state_e        st;
  logic [1:0]        sz_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] stage;
  logic [DATA_W-1:0] word_asm;
  logic [CNT_W-1:0]  last_idx;
  logic              tdo_q;
  logic              crc_match;

  // named internal events
  logic abort, go, ev_start, ev_bit, ev_word, wr_fire, ev_crcbit, ev_crc_last;

  assign abort       = tlr | update;
  assign go          = shift & ~abort & ~cmd_load;
  assign last_idx    = CNT_W'(size_bits(sz_q) - 6'd1);
  assign ev_start    = go & (st == ST_SYNC) & tdi;
  assign ev_bit      = go & (st == ST_DATA);
  assign ev_word     = ev_bit & (bitcnt == last_idx);
  assign wr_fire     = ev_word & ~bus_busy;
  assign ev_crcbit   = go & (st == ST_CRC);
  assign ev_crc_last = ev_crcbit & (bitcnt == CNT_W'(CRC_W - 1));

  always_comb begin
    word_asm         = stage;
    word_asm[bitcnt] = tdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sz_q   <= '0;
      addr_q <= '0;
      left_q <= '0;
      bitcnt <= '0;
      stage  <= '0;
      tdo_q  <= 1'b0;
    end else if (abort) begin
      st     <= ST_IDLE;
      tdo_q  <= 1'b0;
      bitcnt <= '0;
      stage  <= '0;
    end else if (cmd_load) begin
      st     <= ST_SYNC;
      sz_q   <= cmd_size;
      addr_q <= cmd_addr;
      left_q <= cmd_len;
      bitcnt <= '0;
      stage  <= '0;
      tdo_q  <= 1'b0;
    end else if (shift) begin
      case (st)
        ST_SYNC: if (tdi) begin
          bitcnt <= '0;
          stage  <= '0;
          st     <= (left_q == '0) ? ST_CRC : ST_DATA;
        end
        ST_DATA: if (ev_word) begin
          bitcnt <= '0;
          stage  <= '0;
          tdo_q  <= ~bus_busy;
          addr_q <= addr_q + ADDR_W'(size_bytes(sz_q));
          left_q <= left_q - 1'b1;
          st     <= ST_STAT;
        end else begin
          stage[bitcnt] <= tdi;
          bitcnt        <= bitcnt + 1'b1;
        end
        ST_STAT: begin
          tdo_q  <= 1'b0;
          bitcnt <= '0;
          st     <= (left_q == '0) ? ST_CRC : ST_DATA;
        end
        ST_CRC: begin
          bitcnt <= bitcnt + 1'b1;
          if (ev_crc_last) begin
            tdo_q <= crc_match;
            st    <= ST_MATCH;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_size  <= '0;
    end else begin
      bus_wr <= wr_fire;
      if (wr_fire) begin
        bus_addr  <= addr_q;
        bus_wdata <= word_asm & size_mask(sz_q);
        bus_size  <= sz_q;
      end
    end
  end

  assign tdo = tdo_q;

  bwr_crc32 u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd_load),
    .data_en  (ev_bit),
    .data_bit (tdi),
    .rx_en    (ev_crcbit),
    .rx_bit   (tdi),
    .match_now(crc_match)
  );

  bwr_errlog #(.ADDR_W(ADDR_W)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_err  (bus_err),
    .fail_addr(bus_addr),
    .err_clr  (err_clr),
    .err_flag (err_flag),
    .err_addr (err_addr)
  );

endmodule

// File: rtl/bwr_burst_write_chk.sv
module bwr_burst_write_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tlr,
  input logic              update,
  input logic              ev_word,
  input logic              bus_busy,
  input logic              bus_wr,
  input logic              tdo,
  input logic              bus_err,
  input logic              err_clr,
  input logic              err_flag,
  input logic [ADDR_W-1:0] err_addr
);

  // R4: a word taken by an idle bus gives a write and status 1
  a_r4_ready_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word && !bus_busy |=> bus_wr && tdo);

  // R4: each write request lasts one cycle
  a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);

  // R5: a busy bus drops the word and reports status 0
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word && bus_busy |=> !bus_wr && !tdo);

  // R8: an error always leaves the flag set
  a_r8_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> err_flag);

  // R8: the flag and the first address hold until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag && $stable(err_addr));

  // R9: abort silences TDO and the bus
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    tlr || update |=> !tdo && !bus_wr);

endmodule

bind bwr_burst_write bwr_burst_write_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tlr     (tlr),
  .update  (update),
  .ev_word (ev_word),
  .bus_busy(bus_busy),
  .bus_wr  (bus_wr),
  .tdo     (tdo),
  .bus_err (bus_err),
  .err_clr (err_clr),
  .err_flag(err_flag),
  .err_addr(err_addr)
);

// File: tb/test_bwr_burst_write.sv
`timescale 1ns/1ps
module test_bwr_burst_write;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tlr = 1'b0, update = 1'b0, shift = 1'b0, tdi = 1'b0;
  logic        cmd_load = 1'b0;
  logic [1:0]  cmd_size = '0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic        tdo, bus_wr, err_flag;
  logic [31:0] bus_addr, bus_wdata, err_addr;
  logic [1:0]  bus_size;
  logic        bus_busy = 1'b0, bus_err = 1'b0, err_clr = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bwr_burst_write i_bwr_burst_write (
    .clk(clk), .rst_n(rst_n), .tlr(tlr), .update(update), .shift(shift), .tdi(tdi),
    .cmd_load(cmd_load), .cmd_size(cmd_size), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .tdo(tdo), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_busy(bus_busy), .bus_err(bus_err), .err_clr(err_clr),
    .err_flag(err_flag), .err_addr(err_addr)
  );

  typedef struct packed {
    logic [1:0]  size;
    logic [3:0]  len;
    logic [31:0] addr;
    logic [31:0] seed;
    logic [7:0]  busy;
    logic [3:0]  lead;
    logic        bad;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd3, 32'h0000_1000, 32'h0000_00A5, 8'h00, 4'd2, 1'b0},
    '{2'd1, 4'd2, 32'h0000_2002, 32'h1234_BEEF, 8'h00, 4'd0, 1'b0},
    '{2'd2, 4'd3, 32'h4000_0000, 32'hCAFE_F00D, 8'h02, 4'd5, 1'b0},
    '{2'd3, 4'd1, 32'h0000_8000, 32'h0BAD_5EED, 8'h00, 4'd1, 1'b0},
    '{2'd2, 4'd2, 32'h0000_0100, 32'h7777_1111, 8'h00, 4'd0, 1'b1},
    '{2'd0, 4'd0, 32'h0000_0000, 32'h0000_0000, 8'h00, 4'd3, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference CRC, written bit-serially in its own form
  function automatic logic [31:0] ref_crc(logic [31:0] c, logic b);
    logic [31:0] n;
    n = {1'b0, c[31:1]};
    if (c[0] != b) n = n ^ 32'hEDB88320;
    return n;
  endfunction

  function automatic int nbits(logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] word_of(logic [31:0] seed, int i, logic [1:0] s);
    logic [31:0] w;
    w = seed ^ (32'h9E3779B9 * (i + 1));
    return (nbits(s) == 32) ? w : (w & ((32'h1 << nbits(s)) - 1));
  endfunction

  task automatic shift_bit(input logic b);
    @(negedge clk); shift = 1'b1; tdi = b;
    @(posedge clk); #1; shift = 1'b0;
  endtask

  task automatic pulse_cmd(input logic [1:0] s, input logic [31:0] a, input logic [15:0] n);
    @(negedge clk); cmd_load = 1'b1; cmd_size = s; cmd_addr = a; cmd_len = n;
    @(posedge clk); #1; cmd_load = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update = 1'b1;
    @(posedge clk); #1; update = 1'b0;
  endtask

  task automatic run_burst(input vec_t v);
    logic [31:0] crc, a, wd, txc;
    int nb;
    crc = 32'hFFFFFFFF;
    a   = v.addr;
    nb  = nbits(v.size);
    pulse_cmd(v.size, v.addr, 16'(v.len));
    for (int z = 0; z < int'(v.lead); z++) begin
      shift_bit(1'b0);
      check("R1 tdo during leading zeros", 32'(tdo), 32'd0);
    end
    shift_bit(1'b1);
    check("R1 no write on start bit", 32'(bus_wr), 32'd0);
    for (int w = 0; w < int'(v.len); w++) begin
      wd = word_of(v.seed, w, v.size);
      for (int b = 0; b < nb; b++) begin
        if (b == nb - 1) bus_busy = v.busy[w];
        shift_bit(wd[b]);
        crc = ref_crc(crc, wd[b]);
      end
      bus_busy = 1'b0;
      if (v.busy[w]) begin
        check("R5 status 0 when busy", 32'(tdo), 32'd0);
        check("R5 no write when busy", 32'(bus_wr), 32'd0);
      end else begin
        check("R4 status 1", 32'(tdo), 32'd1);
        check("R4 write strobe", 32'(bus_wr), 32'd1);
        check("R3 write address", bus_addr, a);
        check("R1 R2 write data", bus_wdata, wd);
        check("R4 size code", 32'(bus_size), 32'(v.size));
      end
      a = a + 32'(nb / 8);
      shift_bit(1'b1);
      check("R6 status slot no new write", 32'(bus_wr), 32'd0);
    end
    txc = v.bad ? (crc ^ 32'h0000_0001) : crc;
    for (int b = 0; b < 32; b++) begin
      shift_bit(txc[b]);
      if (b < 31) check("R7 tdo low while crc shifts", 32'(tdo), 32'd0);
    end
    check("R7 crc match bit", 32'(tdo), v.bad ? 32'd0 : 32'd1);
    @(negedge clk);
    check("R7 match bit held", 32'(tdo), v.bad ? 32'd0 : 32'd1);
    pulse_update();
    check("R9 tdo low after update", 32'(tdo), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset tdo", 32'(tdo), 32'd0);
    check("R4 reset bus_wr", 32'(bus_wr), 32'd0);
    check("R8 reset err_flag", 32'(err_flag), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_burst(VECS[k]);

    // R9: abort in the middle of a word, then a clean burst
    pulse_cmd(2'd2, 32'h0000_0500, 16'd1);
    shift_bit(1'b1);
    for (int b = 0; b < 10; b++) shift_bit(1'b1);
    pulse_update();
    check("R9 tdo low after mid-word abort", 32'(tdo), 32'd0);
    check("R9 no write after mid-word abort", 32'(bus_wr), 32'd0);
    run_burst('{2'd2, 4'd1, 32'h0000_0600, 32'h5555_AAAA, 8'h00, 4'd0, 1'b0});

    // R9: test-logic-reset during the CRC field
    pulse_cmd(2'd0, 32'h0, 16'd0);
    shift_bit(1'b1);
    for (int b = 0; b < 20; b++) shift_bit(1'b1);
    @(negedge clk); tlr = 1'b1;
    @(posedge clk); #1; tlr = 1'b0;
    check("R9 tdo low after tlr", 32'(tdo), 32'd0);
    shift_bit(1'b1);
    check("R9 idle ignores shifts", 32'(tdo), 32'd0);

    // R8: error register behaviour
    v = '{2'd1, 4'd1, 32'h0000_3000, 32'h0000_0042, 8'h00, 4'd0, 1'b0};
    run_burst(v);
    @(negedge clk); bus_err = 1'b1;
    @(posedge clk); #1; bus_err = 1'b0;
    check("R8 flag set", 32'(err_flag), 32'd1);
    check("R8 first address", err_addr, 32'h0000_3000);
    run_burst('{2'd1, 4'd1, 32'h0000_3100, 32'h0000_0043, 8'h00, 4'd0, 1'b0});
    @(negedge clk); bus_err = 1'b1;
    @(posedge clk); #1; bus_err = 1'b0;
    check("R8 later error keeps address", err_addr, 32'h0000_3000);
    @(negedge clk); bus_err = 1'b1; err_clr = 1'b1;
    @(posedge clk); #1; bus_err = 1'b0; err_clr = 1'b0;
    check("R8 set wins over clear", 32'(err_flag), 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(posedge clk); #1; err_clr = 1'b0;
    check("R8 clear", 32'(err_flag), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule